// File: doc/BRIEF.md
# Comparator event interrupt controller

This block holds the control and status logic for a comparator whose result arrives as one asynchronous digital bit. The bit passes through a synchroniser. The block then looks for a level change of the selected kind: any change, a falling edge only or a rising edge only. When a matching change occurs, a sticky flag is set. An interrupt request is raised while the flag, a local enable and a global enable input are all high.

Software reaches the block through one byte-wide register, with a write strobe and a read port. The flag is cleared in one of two ways: by writing a one to its bit, or by an acknowledge pulse that arrives when the interrupt vector is taken. The block also drives two other outputs. One is a select line that picks an internal bandgap reference for the comparator's positive input. The other is a gated copy of the synchronised comparator bit, sent to the capture input of a timer.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: On reset, every writable field and the flag are zero, the synchroniser is cleared, and rd_data reads 0x00.
- R2: Bit 5 of rd_data shows cmp_in two clock edges after cmp_in changes, and not earlier. Writes to bit 5 and bit 7 have no effect, and bit 7 always reads zero.
- R3: With mode field bits 1:0 = 00, any change of the synchronised comparator bit sets the flag (bit 4). The flag is set three clock edges after cmp_in changes.
- R4: With mode 10, only a falling edge sets the flag. A rising edge leaves it unchanged.
- R5: With mode 11, only a rising edge sets the flag. A falling edge leaves it unchanged.
- R6: Mode 01 is reserved and never sets the flag.
- R7: A write with bit 4 = 1 clears the flag. A write with bit 4 = 0 leaves the flag unchanged.
- R8: A one-cycle pulse on irq_ack clears the flag.
- R9: If an event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.
- R10: irq is high exactly when the flag, the enable bit 3 and glb_ie are all high.
- R11: cap_trig follows the synchronised comparator bit while bit 2 is set, and is low while bit 2 is clear.
- R12: ref_sel is high exactly when bit 6 is set and bod_en is high.
- R13: Reading the register and writing the value back, with another field changed, clears a flag that was read as one. The other field takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator result |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| bod_en | input | 1 | Brown-out detector active |
| ref_sel | output | 1 | 1 selects the internal bandgap as the positive input |
| cap_trig | output | 1 | Comparator bit routed to the timer capture input |
| irq | output | 1 | Interrupt request |

## Verification
A change on cmp_in reaches bit 5 two edges later. The flag it produces appears one edge after that. Register writes and acknowledge pulses act at the next edge. irq, ref_sel and cap_trig follow the register state in the same cycle.

The vector loop applies each stimulus and then lets four edges pass before it samples at a falling edge, so every result has settled by then. Directed tests count edges one at a time to show that bit 5 and the flag are not early. The set-wins test places the clearing write exactly in the cycle in which the event is detected.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int REG_W = 8;
  // Bit positions within the control/status byte
  localparam int B_MODE_LO = 0;
  localparam int B_MODE_HI = 1;
  localparam int B_CAP_EN  = 2;
  localparam int B_IE      = 3;
  localparam int B_FLAG    = 4;
  localparam int B_CMP     = 5;
  localparam int B_BGSEL   = 6;
  localparam int B_RSVD    = 7;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

  // R2: the chain advances one stage per clock
  generate
    if (STAGES >= 2) begin : g_chk
      p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sh[STAGES-1] == $past(sh[STAGES-2]));
    end
  endgenerate
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cur,
  input  evt_mode_e mode,
  output logic      evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  always_comb begin
    case (mode)
      MODE_ANY:  evt = cur ^ prev;
      MODE_FALL: evt = prev & ~cur;
      MODE_RISE: evt = cur & ~prev;
      default:   evt = 1'b0;
    endcase
  end

  // R6: the reserved code never reports an event
  p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RSVD) |-> !evt);
  // R4/R5: a directional event needs a level change against the previous sample
  p_level_change_r5: assert property (@(posedge clk) disable iff (rst)
    evt |-> (cur != $past(cur)));
endmodule

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
  import cmp_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             evt,
  input  logic             irq_ack,
  output logic             bgsel,
  output logic             ie,
  output logic             cap_en,
  output evt_mode_e        mode,
  output logic             flag
);
  logic clr;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[B_RSVD], wr_data[B_CMP]};
  assign clr = (wr_en & wr_data[B_FLAG]) | irq_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      bgsel  <= 1'b0;
      ie     <= 1'b0;
      cap_en <= 1'b0;
      mode   <= MODE_ANY;
    end else if (wr_en) begin
      bgsel  <= wr_data[B_BGSEL];
      ie     <= wr_data[B_IE];
      cap_en <= wr_data[B_CAP_EN];
      mode   <= evt_mode_e'(wr_data[B_MODE_HI:B_MODE_LO]);
    end
  end

  // Set has priority over any clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (!evt && wr_en && wr_data[B_FLAG]) |=> !flag);
  p_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (!evt && irq_ack) |=> !flag);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!evt && !irq_ack && !(wr_en && wr_data[B_FLAG])) |=> $stable(flag));
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             glb_ie,
  input  logic             irq_ack,
  input  logic             bod_en,
  output logic             ref_sel,
  output logic             cap_trig,
  output logic             irq
);
  logic      cmp_s;
  logic      evt;
  logic      bgsel;
  logic      ie;
  logic      cap_en;
  logic      flag;
  evt_mode_e mode;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (cmp_s)
  );

  cmp_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .cur  (cmp_s),
    .mode (mode),
    .evt  (evt)
  );

  cmp_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt     (evt),
    .irq_ack (irq_ack),
    .bgsel   (bgsel),
    .ie      (ie),
    .cap_en  (cap_en),
    .mode    (mode),
    .flag    (flag)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[B_BGSEL]               = bgsel;
    rd_data[B_CMP]                 = cmp_s;
    rd_data[B_FLAG]                = flag;
    rd_data[B_IE]                  = ie;
    rd_data[B_CAP_EN]              = cap_en;
    rd_data[B_MODE_HI:B_MODE_LO]   = mode;
  end

  assign irq      = flag & ie & glb_ie;
  assign ref_sel  = bgsel & bod_en;
  assign cap_trig = cap_en & cmp_s;

  // R11: the capture trigger only changes when the synchronised bit or the gate changes
  p_cap_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ($stable(cmp_s) && $stable(cap_en)) |-> $stable(cap_trig));
  // R10: a request is never raised without the flag having been set
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> rd_data[B_FLAG]);
endmodule

// File: tb/sim_cmp_evt_ctrl.sv
module sim_cmp_evt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       glb_ie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       bod_en = 1'b0;
  logic       ref_sel;
  logic       cap_trig;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_evt_ctrl u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .glb_ie(glb_ie), .irq_ack(irq_ack), .bod_en(bod_en),
    .ref_sel(ref_sel), .cap_trig(cap_trig), .irq(irq)
  );

  // {wr, wdata, cmp, gie, ack, bod, exp_rd, exp_irq, exp_ref, exp_cap}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0}, // enable, mode 00
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h38, 1'b1, 1'b0, 1'b0}, // R3 R10 rise in toggle mode
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h38, 1'b0, 1'b0, 1'b0}, // R10 global enable low
    {1'b1, 8'h18, 1'b1, 1'b1, 1'b0, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0}, // R7 write one clears
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h18, 1'b1, 1'b0, 1'b0}, // R3 fall in toggle mode
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0}, // R8 acknowledge clears
    {1'b1, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0, 1'b0}, // mode 10
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 1'b0}, // R4 rise ignored
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h1A, 1'b1, 1'b0, 1'b0}, // R4 fall sets
    {1'b1, 8'h1B, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b0, 1'b0, 1'b0}, // mode 11 and clear
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3B, 1'b1, 1'b0, 1'b0}, // R5 rise sets
    {1'b1, 8'h1B, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2B, 1'b0, 1'b0, 1'b0}, // R7 clear again
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b0, 1'b0, 1'b0}, // R5 fall ignored
    {1'b1, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0, 1'b0}, // mode 01
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h29, 1'b0, 1'b0, 1'b0}, // R6 rise ignored
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0, 1'b0}, // R6 fall ignored
    {1'b1, 8'hC4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0}, // R2 bit7 ignored, R12 bod low
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 1'b0, 1'b1, 1'b0}, // R12 bandgap chosen
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h74, 1'b0, 1'b1, 1'b1}, // R11 trigger follows
    {1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0}, // R7 zero keeps, R2 bit5 ignored
    {1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0}  // R7 write one clears
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step(); step();
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset outputs", {5'd0, irq, ref_sel, cap_trig}, 8'h00);
    rst = 1'b0;
    step();

    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] e;
      e = VEC[v];
      wr_en   = e[23];
      wr_data = e[22:15];
      cmp_in  = e[14];
      glb_ie  = e[13];
      irq_ack = e[12];
      bod_en  = e[11];
      step();
      wr_en   = 1'b0;
      irq_ack = 1'b0;
      step(); step(); step();
      chk($sformatf("vector %0d rd_data", v), rd_data, e[10:3]);
      chk($sformatf("vector %0d irq/ref/cap", v), {5'd0, irq, ref_sel, cap_trig}, {5'd0, e[2:0]});
    end

    // R2 R3 latency: state is cmp=1, flag=0
    wr_en = 1'b1; wr_data = 8'h08; step(); wr_en = 1'b0; step(); step();
    cmp_in = 1'b0;
    step();
    chk("R2 bit5 not after one edge", {7'd0, rd_data[5]}, 8'h01);
    step();
    chk("R2 bit5 after two edges", {7'd0, rd_data[5]}, 8'h00);
    chk("R3 flag not after two edges", {7'd0, rd_data[4]}, 8'h00);
    step();
    chk("R3 flag after three edges", {7'd0, rd_data[4]}, 8'h01);
    chk("R10 irq with flag", {7'd0, irq}, 8'h01);

    // R9: clearing write in the same cycle the event is seen
    wr_en = 1'b1; wr_data = 8'h18; step(); wr_en = 1'b0;
    chk("R7 flag cleared before R9", {7'd0, rd_data[4]}, 8'h00);
    cmp_in = 1'b1;
    step(); step();
    wr_en = 1'b1; wr_data = 8'h18;
    step();
    wr_en = 1'b0;
    chk("R9 set wins over clear", {7'd0, rd_data[4]}, 8'h01);

    // R13: read-modify-write sets cap enable and clears the flag read as one
    begin
      logic [7:0] rv;
      rv = rd_data;
      wr_en = 1'b1; wr_data = rv | 8'h04;
      step();
      wr_en = 1'b0;
      chk("R13 flag cleared by write-back", {7'd0, rd_data[4]}, 8'h00);
      chk("R13 modified field", {7'd0, rd_data[2]}, 8'h01);
    end

    // R1 reset in mid-run
    cmp_in = 1'b0; bod_en = 1'b1;
    rst = 1'b1;
    step();
    chk("R1 mid-run reset rd_data", rd_data, 8'h00);
    chk("R1 mid-run reset outputs", {5'd0, irq, ref_sel, cap_trig}, 8'h00);
    rst = 1'b0;
    step();

    done = 1'b1;
    finish_run();
  end
endmodule